// File: doc/BRIEF.md
# Paired-Counter Buffered PWM Generator

This block makes three-phase PWM from two 16-bit up-counters that always hold the same value. A single run bit starts both counters. The step rate of both counters is set by the first counter's step-select field. The second counter has its own select field, which is stored as written but has no effect. The cycle register is in slot A of the first channel. When the counter matches the cycle value, both counters clear and a new PWM period begins.

The phase duties are set by three registers:
- phase U by first-channel slot B,
- phase V by second-channel slot A,
- phase W by second-channel slot B.

Each phase has a positive pin and a complementary pin. Two mode bits can turn slots C and D into shadow buffers for slots A and B. In that mode, software writes are steered into the shadows. The shadows are copied into the working registers at the cycle match, so a new duty never takes effect in the middle of a period. Compare-match and overflow flags are sticky and are cleared by writing ones.

Top module: `pwm_pair_sync`

## Requirements
- R1: After a synchronous reset the following hold: status is zero, both counters are zero, the cycle register is 0xFFFF, every duty and buffer register is zero, pwm_p is 0 and pwm_n is all ones.
- R2: Control register (address 0):
  - bit 0 = run,
  - bit 1 = buffer A,
  - bit 2 = buffer B,
  - bits 5:4 = step select for both counters (0 every clock, 1 rising cnt_tick edge, 2 falling edge, 3 both edges),
  - bits 7:6 = second-counter select, which has no effect.
  
  The counters step together only while run is 1, and they always hold equal values.
- R3: A step taken while the count equals the cycle register clears both counters, so one period lasts cycle+1 steps.
- R4: The positive output of a phase is 1 while the count is below that phase's duty, so it is high for duty steps per period. pwm_n is always the inverse of pwm_p.
- R5: A duty of 0 keeps the positive output at 0. A duty greater than or equal to the cycle value keeps it at 1 for the whole period.
- R6: With buffering off, a write to a working register is used from the next clock on.
- R7: With buffer A on, slot C of each channel shadows slot A. With buffer B on, slot D shadows slot B. Writes to a shadowed working address go into its shadow. Each shadow is copied into its working register at the cycle match.
- R8: A step taken while a channel's count equals a slot value sets that slot's flag. Status bit map:
  - channel 0: bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D,
  - channel 1: bits 4 to 7 in the same A, B, C, D order,
  - bits 8 and 9 = overflow of channel 0 and channel 1.
- R9: The flag of slot C or slot D is never set while that slot acts as a shadow.
- R10: With the cycle register at 0xFFFF, the step from 0xFFFF to 0 sets both overflow flags and counts as the cycle match. With any smaller cycle value, no overflow flag is set.
- R11: Flags stay set until a 1 is written to their bit at address 9. A flag set in the same clock as the clear stays set.
- R12: Working addresses are 1 (A0, cycle), 2 (B0, phase U), 5 (A1, phase V) and 6 (B1, phase W). Shadow addresses are 3 (C0), 4 (D0), 7 (C1) and 8 (D1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| cnt_tick | input | 1 | External count tick, edge-selected |
| pwm_p | output | 3 | Positive phase outputs U, V, W |
| pwm_n | output | 3 | Complementary phase outputs |
| status | output | 10 | Sticky compare and overflow flags |

## Verification
The bench targets the following corner cases:
- **Duty limits.** It uses duty zero, duty equal to the cycle value and duty above it. A design with an off-by-one compare would shorten the full-on case by a step or leave a one-step glitch.
- **Shadow writes while stopped.** It loads a shadow while the counters are stopped and shows that the output keeps its old level until the next cycle match. It then shows that the shadow slots' flags stay quiet. A design that bypassed the shadow would switch mid-period. A design that did not mask those flags would report matches against the shadows.
- **Overflow.** It runs a full 0xFFFF cycle to catch an overflow flag that is missing or set early.
- **Step selection.** It switches the tick edge select with a conflicting second-channel select. A second counter that obeyed its own field would give phases V and W a period different from phase U.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 4;
  localparam int NUM_CH    = 2;
  localparam int NUM_SLOTS = 2 * NUM_CH;   // A and B working slots per channel
  localparam int NUM_PH    = 3;
  localparam int NUM_FLAGS = 4 * NUM_CH + NUM_CH;

  localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(9);

  typedef enum logic [1:0] {
    STEP_CLK  = 2'd0,
    STEP_RISE = 2'd1,
    STEP_FALL = 2'd2,
    STEP_BOTH = 2'd3
  } step_sel_e;

  typedef struct packed {
    logic      buf_b;
    logic      buf_a;
    logic      run;
    step_sel_e sel;
  } ctrl_t;

  // slot s: channel s/2, A (s even) or B (s odd)
  function automatic logic [ADDR_W-1:0] work_addr(input int s);
    return ADDR_W'(1 + 4 * (s / 2) + (s % 2));
  endfunction

  function automatic logic [ADDR_W-1:0] shadow_addr(input int s);
    return ADDR_W'(3 + 4 * (s / 2) + (s % 2));
  endfunction

endpackage

// File: rtl/pwm_step_gen.sv
module pwm_step_gen
  import pwm_pair_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  step_sel_e sel,
  input  logic      tick,
  output logic      step
);

  logic tick_q;
  logic tick_rise;
  logic tick_fall;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick;
  end

  assign tick_rise = tick & ~tick_q;
  assign tick_fall = ~tick & tick_q;

  always_comb begin
    case (sel)
      STEP_CLK:  step = run;
      STEP_RISE: step = run & tick_rise;
      STEP_FALL: step = run & tick_fall;
      default:   step = run & (tick_rise | tick_fall);
    endcase
  end

endmodule

// File: rtl/pwm_count_unit.sv
module pwm_count_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         clear,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/pwm_duty_slot.sv
module pwm_duty_slot #(
  parameter int             W         = 16,
  parameter int             AW        = 4,
  parameter logic [AW-1:0]  WORK_ADR  = '0,
  parameter logic [AW-1:0]  SHAD_ADR  = '0,
  parameter logic [W-1:0]   WORK_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          shadow_on,
  input  logic          xfer,
  input  logic [W-1:0]  cnt,
  output logic [W-1:0]  work_q,
  output logic          hit_work,
  output logic          hit_shadow
);

  logic [W-1:0] shad_q;
  logic         wr_work;
  logic         wr_shad;

  assign wr_work = wr_en && (wr_addr == WORK_ADR) && !shadow_on;
  assign wr_shad = wr_en && ((wr_addr == SHAD_ADR) ||
                             ((wr_addr == WORK_ADR) && shadow_on));

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= WORK_INIT;
      shad_q <= '0;
    end else begin
      if (wr_shad) shad_q <= wr_data;
      if (wr_work)                work_q <= wr_data;
      else if (xfer && shadow_on) work_q <= shad_q;
    end
  end

  assign hit_work   = (cnt == work_q);
  assign hit_shadow = (cnt == shad_q);

endmodule

// File: rtl/pwm_phase_out.sv
module pwm_phase_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] cyc,
  output logic         pos,
  output logic         neg
);

  logic active;

  assign active = (duty != '0) && ((cnt < duty) || (duty >= cyc));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= 1'b0;
      neg <= 1'b1;
    end else begin
      pos <= active;
      neg <= ~active;
    end
  end

endmodule

// File: rtl/pwm_pair_sync.sv
module pwm_pair_sync
  import pwm_pair_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [CW-1:0]        wr_data,
  input  logic                 cnt_tick,
  output logic [NUM_PH-1:0]    pwm_p,
  output logic [NUM_PH-1:0]    pwm_n,
  output logic [NUM_FLAGS-1:0] status
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  ctrl_t                ctrl_q;
  logic                 step;
  logic                 wrap;
  logic [CW-1:0]        cnt_ch [NUM_CH];
  logic [CW-1:0]        work   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit_w;
  logic [NUM_SLOTS-1:0] hit_s;
  logic [CW-1:0]        cyc;
  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == ADR_CTRL) begin
      ctrl_q.run   <= wr_data[0];
      ctrl_q.buf_a <= wr_data[1];
      ctrl_q.buf_b <= wr_data[2];
      ctrl_q.sel   <= step_sel_e'(wr_data[5:4]);
    end
  end

  // single step source for both counters, driven by the first select
  pwm_step_gen u_step (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q.run),
    .sel  (ctrl_q.sel),
    .tick (cnt_tick),
    .step (step)
  );

  assign cyc  = work[0];
  assign wrap = step && hit_w[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_count_unit #(.W(CW)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .clear (wrap),
      .cnt   (cnt_ch[c])
    );
    assign set_v[4*NUM_CH + c] = step && (cnt_ch[c] == CNT_MAX) && (cyc == CNT_MAX);
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int CH   = s / 2;
    localparam int IS_B = s % 2;
    logic shadow_on;
    assign shadow_on = (IS_B != 0) ? ctrl_q.buf_b : ctrl_q.buf_a;

    pwm_duty_slot #(
      .W         (CW),
      .AW        (AW),
      .WORK_ADR  (AW'(work_addr(s))),
      .SHAD_ADR  (AW'(shadow_addr(s))),
      .WORK_INIT ((s == 0) ? CNT_MAX : '0)
    ) u_slot (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .shadow_on  (shadow_on),
      .xfer       (wrap),
      .cnt        (cnt_ch[CH]),
      .work_q     (work[s]),
      .hit_work   (hit_w[s]),
      .hit_shadow (hit_s[s])
    );

    assign set_v[4*CH + IS_B]     = step && hit_w[s];
    assign set_v[4*CH + 2 + IS_B] = step && hit_s[s] && !shadow_on;
  end

  for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_ph
    localparam int DI = ph + 1;
    localparam int CH = (ph == 0) ? 0 : 1;
    pwm_phase_out #(.W(CW)) u_out (
      .clk  (clk),
      .rst  (rst),
      .cnt  (cnt_ch[CH]),
      .duty (work[DI]),
      .cyc  (cyc),
      .pos  (pwm_p[ph]),
      .neg  (pwm_n[ph])
    );
  end

  // sticky flags, write-one-to-clear, set has priority
  assign clr_v = (wr_en && wr_addr == ADR_STAT) ? wr_data[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_v) | set_v;
  end

endmodule

// File: rtl/pwm_pair_sync_chk.sv
module pwm_pair_sync_chk #(
  parameter int CW = 16,
  parameter int NF = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic          buf_a,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] cyc,
  input logic [NF-1:0] status,
  input logic [2:0]    pwm_p,
  input logic [2:0]    pwm_n
);

  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
    cnt0 == cnt1) else $error("counters diverged"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt0)) else $error("counter moved without a step"); // R2

  AST_CYCLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (step && cnt0 == cyc) |=> (cnt0 == '0)) else $error("no clear at cycle match"); // R3

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    pwm_n == ~pwm_p) else $error("outputs not complementary"); // R4

  AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (buf_a && !status[2]) |=> !status[2]) else $error("shadow C flag set"); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cyc != '1 && !status[8]) |=> !status[8]) else $error("overflow with short cycle"); // R10

endmodule

bind pwm_pair_sync pwm_pair_sync_chk #(.CW(CW), .NF(pwm_pair_pkg::NUM_FLAGS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .step   (step),
  .buf_a  (ctrl_q.buf_a),
  .cnt0   (cnt_ch[0]),
  .cnt1   (cnt_ch[1]),
  .cyc    (cyc),
  .status (status),
  .pwm_p  (pwm_p),
  .pwm_n  (pwm_n)
);

// File: tb/pwm_pair_sync_bench.sv
module pwm_pair_sync_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cnt_tick = 1'b0;
  logic [2:0]  pwm_p;
  logic [2:0]  pwm_n;
  logic [9:0]  status;

  int nchk = 0;
  int nerr = 0;
  int done_cnt = 0;
  bit finished = 1'b0;
  bit tick_en = 1'b0;
  int tick_ph = 0;

  typedef struct {
    int    phase;
    int    win;
    int    exp_hi;
    string req;
  } item_t;

  item_t sb_q[$];

  always #10 clk = ~clk;   // 50 MHz

  pwm_pair_sync u_pwm_pair_sync (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cnt_tick (cnt_tick),
    .pwm_p    (pwm_p),
    .pwm_n    (pwm_n),
    .status   (status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_hi(input int ph, input int win, input int hi, input string req);
    item_t it;
    it.phase = ph; it.win = win; it.exp_hi = hi; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    int target;
    target = done_cnt + sb_q.size();
    while (done_cnt < target) @(negedge clk);
  endtask

  // tick generator: 2 clocks high, 2 low
  initial begin
    forever begin
      @(negedge clk);
      tick_ph = (tick_ph + 1) % 4;
      cnt_tick = tick_en && (tick_ph < 2);
    end
  end

  // monitor: counts high samples of a phase across one period window
  initial begin
    forever begin
      item_t it;
      int hi;
      int bad;
      while (sb_q.size() == 0) @(negedge clk);
      it = sb_q.pop_front();
      hi = 0; bad = 0;
      repeat (it.win) begin
        @(negedge clk);
        if (pwm_p[it.phase]) hi++;
        if (pwm_n !== ~pwm_p) bad++;
      end
      chk(hi == it.exp_hi, it.req, $sformatf("phase %0d high steps", it.phase), hi, it.exp_hi);
      chk(bad == 0, "R4", "complement mismatches", bad, 0);
      done_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk(status == 10'h0, "R1", "status", status, 0);
    chk(pwm_p == 3'b000, "R1", "pwm_p", pwm_p, 0);
    chk(pwm_n == 3'b111, "R1", "pwm_n", pwm_n, 7);

    // R3 R4 R12 unbuffered run, cycle 9
    wr(4'd1, 16'd9);
    wr(4'd2, 16'd3);
    wr(4'd5, 16'd5);
    wr(4'd6, 16'd7);
    wr(4'd0, 16'h0001);
    idle(30);
    expect_hi(0, 10, 3, "R4");
    expect_hi(1, 10, 5, "R4");
    expect_hi(2, 10, 7, "R3");
    drain();

    // R8 R10 flags after stop; shadows are 0 and unmasked
    wr(4'd0, 16'h0000);
    idle(2);
    chk(status == 10'h0FF, "R8", "flags after run", status, 10'h0FF);

    // R11 write-one-to-clear and stickiness
    wr(4'd9, 16'h0003);
    idle(1);
    chk(status == 10'h0FC, "R11", "partial clear", status, 10'h0FC);
    idle(20);
    chk(status == 10'h0FC, "R11", "flags sticky", status, 10'h0FC);
    wr(4'd9, 16'h03FF);
    idle(1);
    chk(status == 10'h000, "R11", "full clear", status, 0);

    // R5 duty limits
    wr(4'd2, 16'd0);
    wr(4'd5, 16'd12);
    wr(4'd6, 16'd9);
    wr(4'd0, 16'h0001);
    idle(30);
    expect_hi(0, 10, 0, "R5");
    expect_hi(1, 10, 10, "R5");
    expect_hi(2, 10, 10, "R5");
    drain();

    // R6 immediate update while stopped
    wr(4'd0, 16'h0000);
    wr(4'd2, 16'd10);
    idle(2);
    chk(pwm_p[0] == 1'b1, "R6", "U after direct write 10", pwm_p[0], 1);
    wr(4'd2, 16'd0);
    idle(2);
    chk(pwm_p[0] == 1'b0, "R6", "U after direct write 0", pwm_p[0], 0);

    // R7 shadowed updates
    wr(4'd3, 16'd9);
    wr(4'd4, 16'd0);
    wr(4'd7, 16'd12);
    wr(4'd8, 16'd9);
    wr(4'd0, 16'h0006);
    wr(4'd2, 16'd10);
    wr(4'd5, 16'd2);
    wr(4'd6, 16'd6);
    idle(3);
    chk(pwm_p[0] == 1'b0, "R7", "U held before transfer", pwm_p[0], 0);
    wr(4'd9, 16'h03FF);
    wr(4'd0, 16'h0007);
    idle(25);
    expect_hi(0, 10, 10, "R7");
    expect_hi(1, 10, 2, "R7");
    expect_hi(2, 10, 6, "R7");
    drain();

    // R9 shadow flags suppressed
    wr(4'd0, 16'h0006);
    wr(4'd9, 16'h03FF);
    wr(4'd0, 16'h0007);
    idle(30);
    wr(4'd0, 16'h0006);
    idle(2);
    chk(status == 10'h031, "R9", "flags in shadow mode", status, 10'h031);

    // R10 overflow with full-range cycle
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'hFFFF);
    wr(4'd9, 16'h03FF);
    wr(4'd0, 16'h0001);
    idle(1000);
    chk(status[9:8] == 2'b00, "R10", "no early overflow", status[9:8], 0);
    idle(66000);
    wr(4'd0, 16'h0000);
    idle(2);
    chk((status & 10'h301) == 10'h301, "R10", "overflow and cycle flags", status & 10'h301, 10'h301);

    // R2 shared step select; second field set to conflict
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(2);
    wr(4'd1, 16'd9);
    wr(4'd2, 16'd5);
    wr(4'd5, 16'd5);
    tick_en = 1'b1;
    wr(4'd0, 16'h00D1);
    idle(100);
    expect_hi(0, 40, 20, "R2");
    expect_hi(1, 40, 20, "R2");
    expect_hi(2, 40, 0, "R2");
    drain();
    wr(4'd0, 16'h00F1);
    idle(60);
    expect_hi(0, 20, 10, "R2");
    expect_hi(1, 20, 10, "R2");
    drain();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule